// File: doc/BRIEF.md
# Display Controller Identity Probe

This block confirms which display driver chip sits on a parallel system bus before the rest of the chip starts to configure it. When `start_i` is pulsed, it sends a short fixed series of command and parameter writes through a bus-master port. A separate bus driver owns the electrical strobes and the register-select pin. The series first opens write access and brings the chip out of deep standby. It then issues the identity query.

After the query, the probe counts millisecond ticks until a programmable settling time has passed. It then performs one read and throws the result away. The four reads that follow each supply one byte of a 32-bit identifier, starting with the most significant byte. The assembled value is compared against an expected constant. A one-cycle `done_o` pulse reports the identifier and the match flag. Both stay valid until the next accepted start.

Each bus transfer is a request held until the bus driver acknowledges it. Writes carry the register-select level on `bus_rs_o`. Reads return their data with the acknowledge.

Top module: `panel_id_probe`

## Requirements
- R1: A command write drives `bus_rs_o`=0 with the 8-bit command code in `bus_wdata_o[7:0]` and all higher bits zero. A parameter write drives `bus_rs_o`=1. Every read drives `bus_rd_o`=1 and `bus_rs_o`=1.
- R2: After an accepted start, the writes go out in exactly this order: command 0xB0, parameter 0x00, command 0xB1, parameter 0x00, command 0xBF. No read is issued before the 0xBF command is acknowledged.
- R3: No read is requested until `WAIT_MS` rising `ms_tick_i` pulses have been counted after the 0xBF command is acknowledged. While no ticks arrive, the probe issues no read however long it waits.
- R4: The first read after the wait is discarded and does not affect `id_o`.
- R5: The next four reads supply their bits [7:0] to `id_o[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`, in that order. Read data bits [17:8] are ignored.
- R6: `match_o` is 1 exactly when the assembled identifier equals `EXPECTED_ID` (default 0x01221517), and 0 otherwise.
- R7: `done_o` is high for exactly one cycle per sequence, with `id_o` and `match_o` already valid in that cycle. Both hold their values until the next accepted start, which clears them to 0.
- R8: A start that arrives while a sequence is in progress is ignored. It adds no bus transfer and no extra `done_o` pulse.
- R9: Once `bus_req_o` is raised, it stays high with `bus_rs_o`, `bus_rd_o` and `bus_wdata_o` unchanged until the cycle in which `bus_ack_i` is seen.
- R10: After reset, `done_o`, `match_o`, `bus_req_o` and `id_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Begin an identity probe; honoured only when idle |
| ms_tick_i | input | 1 | One-cycle pulse once per millisecond |
| bus_req_o | output | 1 | Transfer request to the bus driver, held until acknowledged |
| bus_rs_o | output | 1 | Register-select level: 0 command, 1 parameter or data |
| bus_rd_o | output | 1 | 1 for a read transfer, 0 for a write |
| bus_wdata_o | output | 18 | Write data; command code in bits [7:0] |
| bus_ack_i | input | 1 | Bus driver completes the current transfer |
| bus_rdata_i | input | 18 | Read data, valid with `bus_ack_i` on a read |
| done_o | output | 1 | One-cycle pulse at the end of a probe |
| match_o | output | 1 | Identifier equals the expected value |
| id_o | output | 32 | Assembled identifier |

## Verification
Several properties are checked on every cycle:
- a pending request keeps its fields stable until it is acknowledged;
- command writes never carry stray upper data bits, and reads always carry register-select high;
- `done_o` never lasts two cycles;
- `match_o` and `id_o` change only at a sequence end, on a read acknowledge or at an accepted start.

Only the directed scenarios can show the rest:
- the exact order of command and parameter values;
- that the dummy read is discarded;
- that the read bytes are placed most significant first;
- that the settling time is counted in ticks and holds off when ticks stop;
- that a start during a busy sequence is ignored.

// File: rtl/panel_id_pkg.sv
package panel_id_pkg;

  localparam logic [7:0] CMD_ACCESS_OPEN  = 8'hB0;
  localparam logic [7:0] CMD_STANDBY_EXIT = 8'hB1;
  localparam logic [7:0] CMD_ID_QUERY     = 8'hBF;

  localparam int unsigned NUM_WRITES = 5;
  localparam int unsigned STEP_W     = $clog2(NUM_WRITES);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WRITE,
    PH_SETTLE,
    PH_READ,
    PH_DONE
  } phase_e;

  typedef struct packed {
    logic       rs;
    logic [7:0] code;
  } wr_op_t;

  // Fixed write series: unlock, leave standby, then query identity.
  function automatic wr_op_t write_op(input logic [STEP_W-1:0] idx);
    wr_op_t op;
    case (idx)
      STEP_W'(0): op = '{rs: 1'b0, code: CMD_ACCESS_OPEN};
      STEP_W'(1): op = '{rs: 1'b1, code: 8'h00};
      STEP_W'(2): op = '{rs: 1'b0, code: CMD_STANDBY_EXIT};
      STEP_W'(3): op = '{rs: 1'b1, code: 8'h00};
      default:    op = '{rs: 1'b0, code: CMD_ID_QUERY};
    endcase
    return op;
  endfunction

endpackage

// File: rtl/panel_id_rst_sync.sv
module panel_id_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];

endmodule

// File: rtl/panel_id_settle.sv
module panel_id_settle #(
  parameter int unsigned WAIT_MS = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic tick_i,
  output logic expired_o
);

  localparam int unsigned CNT_W = $clog2(WAIT_MS + 1) > 0 ? $clog2(WAIT_MS + 1) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expired_o = (cnt_q == CNT_W'(WAIT_MS));

  always_comb begin
    cnt_en = clr_i | (run_i & tick_i & ~expired_o);
    cnt_d  = clr_i ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/panel_id_collect.sv
module panel_id_collect #(
  parameter int unsigned  NUM_ID_BYTES = 4,
  parameter int unsigned  ID_W         = 8 * NUM_ID_BYTES,
  parameter logic [ID_W-1:0] EXPECTED_ID = 32'h0122_1517
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            shift_i,
  input  logic            last_i,
  input  logic [7:0]      byte_i,
  output logic [ID_W-1:0] id_o,
  output logic            match_o
);

  logic [ID_W-1:0] id_q, id_d;
  logic            match_q, match_d;
  logic            en;

  always_comb begin
    en      = clr_i | shift_i;
    id_d    = clr_i ? '0 : {id_q[ID_W-9:0], byte_i};
    match_d = clr_i ? 1'b0 : (last_i ? (id_d == EXPECTED_ID) : match_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q    <= '0;
      match_q <= 1'b0;
    end else if (en) begin
      id_q    <= id_d;
      match_q <= match_d;
    end
  end

  assign id_o    = id_q;
  assign match_o = match_q;

endmodule

// File: rtl/panel_id_seq.sv
module panel_id_seq
  import panel_id_pkg::*;
#(
  parameter int unsigned DATA_W       = 18,
  parameter int unsigned NUM_ID_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ack_i,
  input  logic              settle_done_i,
  output logic              req_o,
  output logic              rs_o,
  output logic              rd_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              settle_clr_o,
  output logic              settle_run_o,
  output logic              shift_o,
  output logic              last_o,
  output logic              clr_o,
  output logic              done_o
);

  localparam int unsigned RD_W = $clog2(NUM_ID_BYTES + 1);

  phase_e            phase_q, phase_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [RD_W-1:0]   rdx_q, rdx_d;
  wr_op_t            op;
  logic              last_write;

  assign op         = write_op(step_q);
  assign last_write = (step_q == STEP_W'(NUM_WRITES - 1));
  assign last_o     = (rdx_q == RD_W'(NUM_ID_BYTES));

  always_comb begin
    phase_d = phase_q;
    step_d  = step_q;
    rdx_d   = rdx_q;
    case (phase_q)
      PH_IDLE: if (start_i) begin
        phase_d = PH_WRITE;
        step_d  = '0;
      end
      PH_WRITE: if (ack_i) begin
        if (last_write) phase_d = PH_SETTLE;
        else            step_d  = step_q + STEP_W'(1);
      end
      PH_SETTLE: if (settle_done_i) begin
        phase_d = PH_READ;
        rdx_d   = '0;
      end
      PH_READ: if (ack_i) begin
        if (last_o) phase_d = PH_DONE;
        else        rdx_d   = rdx_q + RD_W'(1);
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      step_q  <= '0;
      rdx_q   <= '0;
    end else begin
      phase_q <= phase_d;
      step_q  <= step_d;
      rdx_q   <= rdx_d;
    end
  end

  always_comb begin
    req_o        = (phase_q == PH_WRITE) || (phase_q == PH_READ);
    rd_o         = (phase_q == PH_READ);
    rs_o         = rd_o ? 1'b1 : op.rs;
    wdata_o      = (phase_q == PH_WRITE) ? {{(DATA_W-8){1'b0}}, op.code} : '0;
    settle_clr_o = (phase_q == PH_WRITE) && ack_i && last_write;
    settle_run_o = (phase_q == PH_SETTLE);
    shift_o      = (phase_q == PH_READ) && ack_i && (rdx_q != '0);
    clr_o        = (phase_q == PH_IDLE) && start_i;
    done_o       = (phase_q == PH_DONE);
  end

endmodule

// File: rtl/panel_id_probe.sv
module panel_id_probe #(
  parameter int unsigned     DATA_W       = 18,
  parameter int unsigned     NUM_ID_BYTES = 4,
  parameter int unsigned     WAIT_MS      = 50,
  parameter logic [31:0]     EXPECTED_ID  = 32'h0122_1517
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ms_tick_i,
  output logic              bus_req_o,
  output logic              bus_rs_o,
  output logic              bus_rd_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              done_o,
  output logic              match_o,
  output logic [8*NUM_ID_BYTES-1:0] id_o
);

  localparam int unsigned ID_W = 8 * NUM_ID_BYTES;

  logic rst_n_int;
  logic settle_clr, settle_run, settle_done;
  logic shift, last, clr;
  logic unused_rdata_hi;

  assign unused_rdata_hi = ^bus_rdata_i[DATA_W-1:8];

  panel_id_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_int)
  );

  panel_id_seq #(
    .DATA_W       (DATA_W),
    .NUM_ID_BYTES (NUM_ID_BYTES)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_n_int),
    .start_i       (start_i),
    .ack_i         (bus_ack_i),
    .settle_done_i (settle_done),
    .req_o         (bus_req_o),
    .rs_o          (bus_rs_o),
    .rd_o          (bus_rd_o),
    .wdata_o       (bus_wdata_o),
    .settle_clr_o  (settle_clr),
    .settle_run_o  (settle_run),
    .shift_o       (shift),
    .last_o        (last),
    .clr_o         (clr),
    .done_o        (done_o)
  );

  panel_id_settle #(
    .WAIT_MS (WAIT_MS)
  ) u_settle (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .clr_i     (settle_clr),
    .run_i     (settle_run),
    .tick_i    (ms_tick_i),
    .expired_o (settle_done)
  );

  panel_id_collect #(
    .NUM_ID_BYTES (NUM_ID_BYTES),
    .ID_W         (ID_W),
    .EXPECTED_ID  (ID_W'(EXPECTED_ID))
  ) u_collect (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .clr_i   (clr),
    .shift_i (shift),
    .last_i  (last),
    .byte_i  (bus_rdata_i[7:0]),
    .id_o    (id_o),
    .match_o (match_o)
  );

endmodule

// File: rtl/panel_id_probe_chk.sv
module panel_id_probe_chk #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ID_W   = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              bus_req_o,
  input logic              bus_rs_o,
  input logic              bus_rd_o,
  input logic [DATA_W-1:0] bus_wdata_o,
  input logic              bus_ack_i,
  input logic              done_o,
  input logic              match_o,
  input logic [ID_W-1:0]   id_o
);

  // R9: a pending request keeps its fields until acknowledged
  p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_rs_o) &&
                                   $stable(bus_rd_o) && $stable(bus_wdata_o)));

  // R1: command writes carry only an 8-bit code
  p_cmd_width_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_rs_o) |-> (bus_wdata_o[DATA_W-1:8] == '0));

  // R1: reads always use register-select high
  p_read_rs_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_rd_o) |-> bus_rs_o);

  // R7: done lasts a single cycle
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7: match only moves at a sequence end or an accepted start
  p_match_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(match_o) |-> (done_o || $past(start_i)));

  // R5: identifier only moves on a read acknowledge or a start
  p_id_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(id_o) |-> ($past(bus_ack_i && bus_rd_o) || $past(start_i)));

endmodule

bind panel_id_probe panel_id_probe_chk #(
  .DATA_W (DATA_W),
  .ID_W   (8 * NUM_ID_BYTES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .bus_req_o   (bus_req_o),
  .bus_rs_o    (bus_rs_o),
  .bus_rd_o    (bus_rd_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_ack_i   (bus_ack_i),
  .done_o      (done_o),
  .match_o     (match_o),
  .id_o        (id_o)
);

// File: tb/panel_id_probe_tb.sv
module panel_id_probe_tb;

  localparam int unsigned DATA_W  = 18;
  localparam int unsigned WAIT_MS = 50;

  logic              clk;
  logic              rst_n;
  logic              start;
  logic              ms_tick;
  logic              bus_req, bus_rs, bus_rd, bus_ack;
  logic [DATA_W-1:0] bus_wdata, bus_rdata;
  logic              done, match;
  logic [31:0]       id;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;

  // bus model state
  logic [DATA_W-1:0] rd_vals [5];
  int                rd_ptr = 0;
  logic              wr_rs  [16];
  logic [DATA_W-1:0] wr_dat [16];
  int                wr_n = 0;
  int                lat = 0;
  logic              tick_en = 1'b1;
  int                ticks_total = 0;
  int                bf_tick = 0;
  int                first_rd_tick = -1;
  int                done_cnt = 0;

  panel_id_probe #(
    .DATA_W  (DATA_W),
    .WAIT_MS (WAIT_MS)
  ) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .ms_tick_i   (ms_tick),
    .bus_req_o   (bus_req),
    .bus_rs_o    (bus_rs),
    .bus_rd_o    (bus_rd),
    .bus_wdata_o (bus_wdata),
    .bus_ack_i   (bus_ack),
    .bus_rdata_i (bus_rdata),
    .done_o      (done),
    .match_o     (match),
    .id_o        (id)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // millisecond tick source
  initial begin
    ms_tick = 1'b0;
    forever begin
      repeat (4) @(posedge clk);
      #2;
      if (tick_en) begin
        ms_tick = 1'b1;
        ticks_total++;
      end
      @(posedge clk);
      #2 ms_tick = 1'b0;
    end
  end

  // bus driver model: acknowledge on the second cycle of a request
  initial begin
    bus_ack   = 1'b0;
    bus_rdata = '0;
    forever begin
      @(posedge clk);
      #1;
      cycles++;
      if (bus_ack) begin
        bus_ack = 1'b0;
        lat     = 0;
      end else if (bus_req) begin
        lat++;
        if (bus_rd && lat == 1 && rd_ptr == 0 && first_rd_tick < 0)
          first_rd_tick = ticks_total;
        if (lat == 2) begin
          bus_ack = 1'b1;
          if (bus_rd) begin
            bus_rdata = (rd_ptr < 5) ? rd_vals[rd_ptr] : '0;
            rd_ptr++;
          end else begin
            if (wr_n < 16) begin
              wr_rs[wr_n]  = bus_rs;
              wr_dat[wr_n] = bus_wdata;
            end
            wr_n++;
            if (!bus_rs && bus_wdata[7:0] == 8'hBF) bf_tick = ticks_total;
          end
        end
      end
    end
  end

  // done pulse counter
  initial forever begin
    @(negedge clk);
    if (done) done_cnt++;
  end

  // watchdog
  initial begin
    wait (cycles > 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic clear_log();
    wr_n = 0;
    rd_ptr = 0;
    first_rd_tick = -1;
  endtask

  task automatic pulse_start();
    @(posedge clk);
    #1 start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
  endtask

  task automatic wait_done(input int prev);
    int n = 0;
    while (done_cnt == prev && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic check_writes(input string tag);
    logic [7:0] exp_code [5] = '{8'hB0, 8'h00, 8'hB1, 8'h00, 8'hBF};
    logic       exp_rs   [5] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
    check(wr_n == 5, "R2", {tag, " write count"}, wr_n, 5);
    for (int i = 0; i < 5; i++) begin
      check(wr_rs[i] == exp_rs[i], "R1", {tag, " register-select"}, wr_rs[i], exp_rs[i]);
      check(wr_dat[i] == DATA_W'(exp_code[i]), "R2", {tag, " write data"},
            wr_dat[i], exp_code[i]);
    end
  endtask

  task automatic t_reset_state();
    check(done == 1'b0, "R10", "done after reset", done, 0);
    check(match == 1'b0, "R10", "match after reset", match, 0);
    check(bus_req == 1'b0, "R10", "request after reset", bus_req, 0);
    check(id == 32'h0, "R10", "id after reset", id, 0);
  endtask

  task automatic t_matching_panel();
    int prev;
    rd_vals = '{18'h3FFFF, 18'h3FF01, 18'h2AA22, 18'h15515, 18'h3C017};
    clear_log();
    prev = done_cnt;
    pulse_start();
    wait_done(prev);
    // done cycle: id and match valid
    check(done == 1'b1, "R7", "done seen", done, 1);
    check(id == 32'h0122_1517, "R5", "id assembled MSB first", id, 32'h0122_1517);
    check(match == 1'b1, "R6", "match for expected id", match, 1);
    check_writes("match run");
    check(first_rd_tick - bf_tick >= int'(WAIT_MS) &&
          first_rd_tick - bf_tick <= int'(WAIT_MS) + 1,
          "R3", "ticks before first read", first_rd_tick - bf_tick, WAIT_MS);
    check(rd_ptr == 5, "R4", "reads including dummy", rd_ptr, 5);
    repeat (20) @(negedge clk);
    check(done_cnt == prev + 1, "R7", "single done pulse", done_cnt - prev, 1);
  endtask

  task automatic t_hold_until_start();
    int prev;
    repeat (60) @(negedge clk);
    check(match == 1'b1, "R7", "match held while idle", match, 1);
    check(id == 32'h0122_1517, "R7", "id held while idle", id, 32'h0122_1517);
    rd_vals = '{18'h00000, 18'h00001, 18'h00022, 18'h00015, 18'h00017};
    clear_log();
    prev = done_cnt;
    pulse_start();
    @(negedge clk);
    check(match == 1'b0, "R7", "match cleared by start", match, 0);
    check(id == 32'h0, "R7", "id cleared by start", id, 0);
    wait_done(prev);
    check(match == 1'b1, "R6", "match after upper bits zero", match, 1);
  endtask

  task automatic t_mismatch();
    int prev;
    rd_vals = '{18'h00001, 18'h3FE01, 18'h00022, 18'h00015, 18'h00018};
    clear_log();
    prev = done_cnt;
    pulse_start();
    wait_done(prev);
    check(id == 32'h0122_1518, "R5", "id for other chip", id, 32'h0122_1518);
    check(match == 1'b0, "R6", "no match for other chip", match, 0);
  endtask

  task automatic t_tick_holdoff();
    int prev;
    int n = 0;
    rd_vals = '{18'h000AA, 18'h00001, 18'h00022, 18'h00015, 18'h00017};
    clear_log();
    tick_en = 1'b0;
    prev = done_cnt;
    pulse_start();
    while (wr_n < 5 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (400) @(negedge clk);
    check(rd_ptr == 0 && first_rd_tick < 0, "R3", "no read without ticks", rd_ptr, 0);
    check(done_cnt == prev, "R3", "no completion without ticks", done_cnt - prev, 0);
    tick_en = 1'b1;
    wait_done(prev);
    check(id == 32'h0122_1517, "R4", "dummy read discarded", id, 32'h0122_1517);
  endtask

  task automatic t_busy_start();
    int prev;
    rd_vals = '{18'h12345, 18'h00001, 18'h00022, 18'h00015, 18'h00017};
    clear_log();
    prev = done_cnt;
    pulse_start();
    repeat (10) @(negedge clk);
    pulse_start();
    repeat (60) @(negedge clk);
    pulse_start();
    wait_done(prev);
    repeat (100) @(negedge clk);
    check(done_cnt == prev + 1, "R8", "one done despite busy starts", done_cnt - prev, 1);
    check(wr_n == 5, "R8", "no extra writes from busy starts", wr_n, 5);
    check(bus_req == 1'b0, "R8", "bus idle after sequence", bus_req, 0);
    check_writes("busy run");
  endtask

  initial begin
    start = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_matching_panel();
    t_hold_until_start();
    t_mismatch();
    t_tick_holdoff();
    t_busy_start();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule